// File: doc/BRIEF.md
# Protection Region Range Decoder

This block turns the match mode and word-granular address register of each memory protection entry into an inclusive pair of byte addresses, start and end. An access checker can then test an address against a plain range compare and does not have to decode anything itself. There are four match modes. A disabled entry spans the whole address space. Top-of-range mode spans from the previous entry's address up to just below its own. The 4-byte mode covers one aligned word. The power-of-two mode sizes its region from the run of trailing ones in the register.

The block keeps the mode and address register of every entry, written through a single update port. The entry being written and its successor are decoded again one cycle after the write. The successor is included because its top-of-range bounds depend on the written address. A combinational read port returns the stored bounds of any entry, together with the mode they were decoded from.

Top module: `prot_region_decoder`

## Requirements
- R1: After reset every entry reads mode 0 (disabled) with start 0 and end equal to the maximum byte address 2^(ADDR_W+2)-1.
- R2: Mode field encoding is 0 = disabled, 1 = top-of-range, 2 = aligned 4-byte, 3 = power-of-two. A disabled entry reads start 0 and end 2^(ADDR_W+2)-1.
- R3: In top-of-range mode the start is the previous entry's address register times 4, and the end is the entry's own register times 4 minus 1, modulo 2^(ADDR_W+2). A zero register therefore gives the maximum address as its end.
- R4: In top-of-range mode, entry 0 takes zero as its previous address.
- R5: In aligned 4-byte mode the start is the register times 4 and the end is the start plus 3.
- R6: In power-of-two mode, let t be the number of trailing ones in the register, with t < ADDR_W. The region is 2^(t+3) bytes long. Its start is the register with its low t+1 bits cleared, times 4. A register ending in binary 0 gives 8 bytes, and one ending in 01 gives 16 bytes.
- R7: In power-of-two mode an all-ones register gives start 0 and end 2^(ADDR_W+2)-1.
- R8: An update sampled on clock edge k writes the entry's mode and register. The decoded bounds of that entry and of its successor are readable after edge k+1. The read port is combinational in rdIdx.
- R9: A write to entry i also re-derives the bounds of entry i+1, so a top-of-range entry i+1 follows a new address in entry i without being written itself. Bounds of entries that were neither written nor the successor of a written entry do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Write one entry's mode and address register |
| updIdx | input | $clog2(NUM_ENTRIES) | Entry written |
| updMode | input | 2 | New match mode (R2 encoding) |
| updAddr | input | ADDR_W | New word-granular address register |
| rdIdx | input | $clog2(NUM_ENTRIES) | Entry whose bounds are read |
| rdMode | output | 2 | Mode the read bounds were decoded from |
| rdStart | output | ADDR_W+2 | Inclusive start byte address |
| rdEnd | output | ADDR_W+2 | Inclusive end byte address |

## Verification
The case hardest to reach from the ports is a successor that must be refreshed by its neighbour's write. That means a top-of-range entry whose start moves only because entry i-1 was written. Decoding the successor is easy to get wrong, or to skip, without any visible effect elsewhere. The stimulus writes entries at random with modes chosen at random, so top-of-range entries often sit behind rewritten neighbours, and it re-reads each written entry and its successor. Register values are drawn with controlled runs of trailing ones, from none up to all ones. Directed cases cover entry 0 in top-of-range mode and a zero top-of-range register.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } regionMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;       // write mode/address of the addressed entry
    logic recalc;      // re-derive bounds of the pending entry
    logic recalcNext;  // also re-derive its successor
  } prdStrobe_t;
endpackage

// File: rtl/prd_decode.sv
`timescale 1ns/1ps
module prd_decode #(
  parameter int ADDR_W = 32,
  localparam int BA_W = ADDR_W + 2
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prevAddr,
  output logic [BA_W-1:0]   startAddr,
  output logic [BA_W-1:0]   endAddr
);
  import prd_pkg::*;

  localparam int CW = $clog2(BA_W + 2);

  logic [CW-1:0]   onesRun;
  logic [CW-1:0]   shAmt;
  logic [BA_W-1:0] lowMask;
  logic [BA_W-1:0] ownByte;
  logic [BA_W-1:0] prevByte;

  // priority encoder on the inverted register: lowest zero bit position
  always_comb begin
    onesRun = CW'(ADDR_W);
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (!addr[i]) onesRun = CW'(i);
    end
  end

  assign shAmt    = onesRun + CW'(3);
  assign lowMask  = ~({BA_W{1'b1}} << shAmt);
  assign ownByte  = {addr, 2'b00};
  assign prevByte = {prevAddr, 2'b00};

  always_comb begin
    unique case (regionMode_e'(mode))
      MODE_TOR: begin
        startAddr = prevByte;
        endAddr   = ownByte - BA_W'(1);
      end
      MODE_NA4: begin
        startAddr = ownByte;
        endAddr   = ownByte + BA_W'(3);
      end
      MODE_NAPOT: begin
        startAddr = ownByte & ~lowMask;
        endAddr   = ownByte | lowMask;
      end
      default: begin
        startAddr = '0;
        endAddr   = '1;
      end
    endcase
  end
endmodule

// File: rtl/prd_ctrl.sv
`timescale 1ns/1ps
module prd_ctrl #(
  parameter int NUM_ENTRIES = 8,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updValid,
  input  logic [IW-1:0]        updIdx,
  output prd_pkg::prdStrobe_t  strobe,
  output logic [IW-1:0]        recalcIdx
);
  logic idxOk;
  logic pendQ;

  assign idxOk = int'(updIdx) < NUM_ENTRIES;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      recalcIdx <= '0;
    end else begin
      pendQ <= updValid && idxOk;
      if (updValid && idxOk) recalcIdx <= updIdx;
    end
  end

  assign strobe.cfgWr      = updValid && idxOk;
  assign strobe.recalc     = pendQ;
  assign strobe.recalcNext = pendQ && (int'(recalcIdx) + 1 < NUM_ENTRIES);
endmodule

// File: rtl/prd_datapath.sv
`timescale 1ns/1ps
module prd_datapath #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W = 32,
  localparam int IW = $clog2(NUM_ENTRIES),
  localparam int BA_W = ADDR_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  prd_pkg::prdStrobe_t strobe,
  input  logic [IW-1:0]       cfgIdx,
  input  logic [1:0]          cfgMode,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [IW-1:0]       recalcIdx,
  input  logic [IW-1:0]       rdIdx,
  output logic [1:0]          rdMode,
  output logic [BA_W-1:0]     rdStart,
  output logic [BA_W-1:0]     rdEnd
);
  logic [1:0]        modeQ  [NUM_ENTRIES];
  logic [ADDR_W-1:0] addrQ  [NUM_ENTRIES];
  logic [1:0]        bModeQ [NUM_ENTRIES];
  logic [BA_W-1:0]   startQ [NUM_ENTRIES];
  logic [BA_W-1:0]   endQ   [NUM_ENTRIES];

  logic [IW-1:0]     idxPrev, idxNext;
  logic [ADDR_W-1:0] selfPrev;
  logic [1:0]        selfMode, nextMode;
  logic [ADDR_W-1:0] selfAddr, nextAddr;
  logic [BA_W-1:0]   selfStart, selfEnd, nextStart, nextEnd;

  assign idxPrev  = recalcIdx - IW'(1);
  assign idxNext  = recalcIdx + IW'(1);
  assign selfMode = modeQ[recalcIdx];
  assign selfAddr = addrQ[recalcIdx];
  assign selfPrev = (recalcIdx == '0) ? '0 : addrQ[idxPrev];
  assign nextMode = strobe.recalcNext ? modeQ[idxNext] : 2'd0;
  assign nextAddr = strobe.recalcNext ? addrQ[idxNext] : '0;

  prd_decode #(.ADDR_W(ADDR_W)) u_decSelf (
    .mode(selfMode), .addr(selfAddr), .prevAddr(selfPrev),
    .startAddr(selfStart), .endAddr(selfEnd)
  );

  prd_decode #(.ADDR_W(ADDR_W)) u_decNext (
    .mode(nextMode), .addr(nextAddr), .prevAddr(selfAddr),
    .startAddr(nextStart), .endAddr(nextEnd)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hitSelf, hitNext;
    assign hitSelf = strobe.recalc && (int'(recalcIdx) == e);
    assign hitNext = strobe.recalcNext && (int'(recalcIdx) + 1 == e);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ[e]  <= 2'd0;
        addrQ[e]  <= '0;
        bModeQ[e] <= 2'd0;
        startQ[e] <= '0;
        endQ[e]   <= '1;
      end else begin
        if (strobe.cfgWr && (int'(cfgIdx) == e)) begin
          modeQ[e] <= cfgMode;
          addrQ[e] <= cfgAddr;
        end
        if (hitSelf) begin
          bModeQ[e] <= selfMode;
          startQ[e] <= selfStart;
          endQ[e]   <= selfEnd;
        end else if (hitNext) begin
          bModeQ[e] <= nextMode;
          startQ[e] <= nextStart;
          endQ[e]   <= nextEnd;
        end
      end
    end
  end

  assign rdMode  = bModeQ[rdIdx];
  assign rdStart = startQ[rdIdx];
  assign rdEnd   = endQ[rdIdx];
endmodule

// File: rtl/prot_region_decoder.sv
`timescale 1ns/1ps
module prot_region_decoder #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W = 32,
  localparam int IW = $clog2(NUM_ENTRIES),
  localparam int BA_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic [IW-1:0]     updIdx,
  input  logic [1:0]        updMode,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [IW-1:0]     rdIdx,
  output logic [1:0]        rdMode,
  output logic [BA_W-1:0]   rdStart,
  output logic [BA_W-1:0]   rdEnd
);
  prd_pkg::prdStrobe_t strobe;
  logic [IW-1:0]       recalcIdx;

  prd_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updIdx(updIdx),
    .strobe(strobe), .recalcIdx(recalcIdx)
  );

  prd_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgIdx(updIdx), .cfgMode(updMode), .cfgAddr(updAddr),
    .recalcIdx(recalcIdx), .rdIdx(rdIdx),
    .rdMode(rdMode), .rdStart(rdStart), .rdEnd(rdEnd)
  );
endmodule

// File: rtl/prd_checker.sv
`timescale 1ns/1ps
module prd_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W = 32,
  localparam int IW = $clog2(NUM_ENTRIES),
  localparam int BA_W = ADDR_W + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic [IW-1:0]     rdIdx,
  input logic [1:0]        rdMode,
  input logic [BA_W-1:0]   rdStart,
  input logic [BA_W-1:0]   rdEnd
);
  logic [BA_W-1:0] span;
  assign span = rdEnd - rdStart;

  AST_OFF_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rdMode == 2'd0 |-> (rdStart == '0 && rdEnd == '1)); // R2

  AST_TOR_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    rdMode == 2'd1 |-> (rdStart[1:0] == 2'b00 && rdEnd[1:0] == 2'b11)); // R3

  AST_NA4_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    rdMode == 2'd2 |-> (span == BA_W'(3) && rdStart[1:0] == 2'b00)); // R5

  AST_NAPOT_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    rdMode == 2'd3 |-> (((span & (span + BA_W'(1))) == '0)
                        && ((rdStart & span) == '0) && span >= BA_W'(7))); // R6

  AST_BOUNDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updValid) && !$past(updValid, 2) && $stable(rdIdx))
      |-> ($stable(rdStart) && $stable(rdEnd) && $stable(rdMode))); // R9
endmodule

bind prot_region_decoder prd_checker #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .updValid(updValid), .rdIdx(rdIdx),
  .rdMode(rdMode), .rdStart(rdStart), .rdEnd(rdEnd)
);

// File: tb/prot_region_decoder_bench.sv
`timescale 1ns/1ps
module prot_region_decoder_bench;
  localparam int N    = 8;
  localparam int AW   = 32;
  localparam int IW   = $clog2(N);
  localparam int BA_W = AW + 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            updValid = 1'b0;
  logic [IW-1:0]   updIdx = '0;
  logic [1:0]      updMode = '0;
  logic [AW-1:0]   updAddr = '0;
  logic [IW-1:0]   rdIdx = '0;
  logic [1:0]      rdMode;
  logic [BA_W-1:0] rdStart, rdEnd;

  int checks = 0;
  int fails  = 0;

  logic [1:0]    mMode [N];
  logic [AW-1:0] mAddr [N];

  always #2.5 clk = ~clk;

  prot_region_decoder #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_prot_region_decoder (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updIdx(updIdx),
    .updMode(updMode), .updAddr(updAddr), .rdIdx(rdIdx),
    .rdMode(rdMode), .rdStart(rdStart), .rdEnd(rdEnd)
  );

  function automatic int onesRun(logic [AW-1:0] a);
    int t = 0;
    while (t < AW && a[t]) t++;
    return t;
  endfunction

  function automatic logic [BA_W-1:0] expStart(int i);
    logic [AW-1:0] a = mAddr[i];
    case (mMode[i])
      2'd1: return (i == 0) ? '0 : {mAddr[i-1], 2'b00};
      2'd2: return {a, 2'b00};
      2'd3: begin
        int t = onesRun(a);
        if (t == AW) return '0;
        return {a, 2'b00} & ~((BA_W'(1) << (t + 3)) - BA_W'(1));
      end
      default: return '0;
    endcase
  endfunction

  function automatic logic [BA_W-1:0] expEnd(int i);
    logic [AW-1:0] a = mAddr[i];
    case (mMode[i])
      2'd1: return {a, 2'b00} - BA_W'(1);
      2'd2: return {a, 2'b00} + BA_W'(3);
      2'd3: begin
        int t = onesRun(a);
        logic [BA_W:0] sz;
        if (t == AW) return '1;
        sz = (BA_W+1)'(1) << (t + 3);
        return expStart(i) + BA_W'(sz - 1);
      end
      default: return '1;
    endcase
  endfunction

  function automatic string tagFor(int i);
    case (mMode[i])
      2'd1: return (i == 0) ? "R4" : "R3";
      2'd2: return "R5";
      2'd3: return (onesRun(mAddr[i]) == AW) ? "R7" : "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic checkEntry(int i, string tag);
    @(negedge clk);
    rdIdx = IW'(i);
    #1;
    checks++;
    if (rdMode !== mMode[i] || rdStart !== expStart(i) || rdEnd !== expEnd(i)) begin
      fails++;
      $display("FAIL %s entry %0d: got mode %0d start %h end %h, expected mode %0d start %h end %h",
               tag, i, rdMode, rdStart, rdEnd, mMode[i], expStart(i), expEnd(i));
    end
  endtask

  // write, then wait until the decoded bounds are readable (R8)
  task automatic writeEntry(int i, logic [1:0] m, logic [AW-1:0] a);
    @(negedge clk);
    updValid = 1'b1; updIdx = IW'(i); updMode = m; updAddr = a;
    @(negedge clk);
    updValid = 1'b0;
    mMode[i] = m; mAddr[i] = a;
    @(posedge clk);
  endtask

  function automatic logic [AW-1:0] patAddr();
    int t = int'($urandom_range(AW, 0));
    logic [AW-1:0] r = AW'($urandom());
    if (t == AW) return '1;
    return ((r << (t + 1)) | ((AW'(1) << t) - AW'(1)));
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin mMode[i] = 2'd0; mAddr[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every entry
    for (int i = 0; i < N; i++) checkEntry(i, "R1");

    // R8: bounds readable exactly one edge after the write edge
    @(negedge clk);
    updValid = 1'b1; updIdx = IW'(2); updMode = 2'd2; updAddr = 32'h0000_1000;
    rdIdx = IW'(2);
    @(negedge clk);
    updValid = 1'b0;
    #1; checks++;
    if (rdMode !== 2'd0) begin
      fails++; $display("FAIL R8 early: got mode %0d expected 0", rdMode);
    end
    mMode[2] = 2'd2; mAddr[2] = 32'h0000_1000;
    checkEntry(2, "R8");

    // R5 directed
    writeEntry(3, 2'd2, 32'hFFFF_FFFF); checkEntry(3, "R5");
    // R6: register ending 0 -> 8 bytes, ending 01 -> 16 bytes
    writeEntry(4, 2'd3, 32'h0000_0100); checkEntry(4, "R6");
    writeEntry(4, 2'd3, 32'h0000_0101); checkEntry(4, "R6");
    // R7: all ones
    writeEntry(5, 2'd3, 32'hFFFF_FFFF); checkEntry(5, "R7");
    writeEntry(5, 2'd3, 32'h7FFF_FFFF); checkEntry(5, "R6");
    // R4: entry 0 top-of-range
    writeEntry(0, 2'd1, 32'h0000_0040); checkEntry(0, "R4");
    // R3: zero register wraps end to maximum
    writeEntry(6, 2'd1, 32'h0000_0000); checkEntry(6, "R3");
    // R9: entry 7 TOR follows writes to entry 6
    writeEntry(7, 2'd1, 32'h0000_9000); checkEntry(7, "R3");
    writeEntry(6, 2'd0, 32'h0000_4000); checkEntry(7, "R9");
    writeEntry(6, 2'd3, 32'h0000_5003); checkEntry(7, "R9");
    checkEntry(6, "R6");
    // R9: unrelated entries untouched
    checkEntry(3, "R9");
    checkEntry(0, "R9");

    // R2: disabled after use
    writeEntry(4, 2'd0, 32'h1234_5678); checkEntry(4, "R2");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int i = int'($urandom_range(N - 1, 0));
      logic [1:0] m = 2'($urandom());
      logic [AW-1:0] a = ($urandom_range(1, 0) == 0) ? patAddr() : AW'($urandom());
      writeEntry(i, m, a);
      checkEntry(i, tagFor(i));
      if (i + 1 < N) checkEntry(i + 1, (mMode[i+1] == 2'd1) ? "R9" : tagFor(i + 1));
    end
    for (int i = 0; i < N; i++) checkEntry(i, tagFor(i));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule